// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a four-wire serial slave that gives a host access to a small bank of 8-bit configuration registers at 6-bit addresses. The chip select, serial clock and data input are brought into the block's own clock domain through synchronizers. Edges of the serial clock are detected by oversampling them, and a frame is assembled and committed from those edges. Every register starts at a fixed baseline after reset. The bank holds one read-only status bit that follows an external false-lock flag, one bit that clears itself after it is written, and two control bits that stay set until software writes them back to 0.

Read data lags one frame behind the command. The byte shifted out during the first eight serial clocks of a frame belongs to the register addressed by the previous complete frame. In automatic readback mode this holds for every frame, whatever the earlier command was. In explicit mode, only a frame that follows a read drives data. After a write, the data pin stays released.

Top module: `ser_reg_port`

## Requirements
- R1: After reset every register holds its baseline: 0x00=0x04, 0x01=0x00, 0x02=0x24, 0x04=0x74, 0x05=0x0E, 0x15=0x61, 0x1C=0x61, 0x28=0x0E, 0x3C=0x00, 0x3D=0x00, 0x3E=0x48. The readback pointer resets to address 0x00.
- R2: A frame is 16 SCLK cycles with chip select low and SCLK low whenever chip select changes. SDI is sampled on SCLK rising edges, MSB first, as {write(1)/read(0), reserved, addr[5:0], data[7:0]}. A write frame updates the writable bits of the addressed register on its 16th rising edge.
- R3: With bit 0 of register 0x3C clear (automatic readback), SDO is enabled during the first 8 SCLK cycles of every frame. It carries, MSB first, the value of the register addressed by the previous complete frame, whether that frame was a read or a write.
- R4: With bit 0 of register 0x3C set (explicit mode), a frame that follows a complete read frame drives the value of the register that read addressed. The second frame may be a read or a write.
- R5: In explicit mode, SDO stays disabled during a frame that follows a write frame, and during the first frame after reset.
- R6: The SDO enable is low whenever chip select is high and during SCLK cycles 9 to 16. SDO changes only after SCLK falling edges or at the start of a frame.
- R7: A frame in which chip select rises before the 16th rising edge changes no register and leaves the readback pointer as it was.
- R8: Register 0x07 is read-only. Bit 0 reads the synchronized lock_err_i, the other bits read 0, and writes to it have no effect.
- R9: Writing 1 to bit 0 of register 0x28 gives exactly one clk_i-cycle pulse on dll_rst_o. That bit always reads 0, and bits 7:1 are stored normally.
- R10: Bit 7 of register 0x05 (ser_rst_o) and bit 2 of register 0x3D (test_rst_o) stay set across any number of frames until written 0.
- R11: Reads from unused addresses return 0, and writes to them are ignored. Register 0x3E reads 0x48 and ignores writes. Bits outside the writable mask (0x00: 0x6D, 0x02: 0x3F, 0x04: 0x7F, 0x05: 0x8F, 0x3C: 0x01, 0x3D: 0x36) keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, several times faster than SCLK |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, valid when sdo_en_o is high |
| sdo_en_o | output | 1 | SDO output enable; low means the pin is released |
| lock_err_i | input | 1 | External false-lock flag, asynchronous |
| regs_o | output | 96 | Read view of all twelve registers, slot n at bits 8n+7:8n |
| dll_rst_o | output | 1 | One-cycle pulse from the self-clearing bit |
| ser_rst_o | output | 1 | Sticky serializer reset control |
| test_rst_o | output | 1 | Sticky test reset control |

## Verification
The commit of one frame's write and the readback snapshot for the next frame are the two operations that can meet. With a short chip-select gap, the frame start follows the commit by only a few clk_i cycles. The bench writes a register and reads it back in the very next frame, and it expects the new value, not the old one. It also toggles the mode bit itself: the frame that follows such a write must already obey the new read style. For the disabled direction, that means a released SDO.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int DW   = 8;
  localparam int AW   = 6;
  localparam int NREG = 12;

  typedef enum logic [1:0] {K_RW, K_RO_STAT, K_RO_CONST, K_SELFCLR} kind_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] base;
    logic [DW-1:0] wmask;
    kind_e         kind;
  } reg_desc_t;

  localparam reg_desc_t REG_TAB [NREG] = '{
    '{6'h00, 8'h04, 8'h6D, K_RW},
    '{6'h01, 8'h00, 8'hFF, K_RW},
    '{6'h02, 8'h24, 8'h3F, K_RW},
    '{6'h04, 8'h74, 8'h7F, K_RW},
    '{6'h05, 8'h0E, 8'h8F, K_RW},
    '{6'h07, 8'h00, 8'h00, K_RO_STAT},
    '{6'h15, 8'h61, 8'hFF, K_RW},
    '{6'h1C, 8'h61, 8'hFF, K_RW},
    '{6'h28, 8'h0E, 8'hFE, K_SELFCLR},
    '{6'h3C, 8'h00, 8'h01, K_RW},
    '{6'h3D, 8'h00, 8'h36, K_RW},
    '{6'h3E, 8'h48, 8'h00, K_RO_CONST}
  };

  localparam int IDX_LINK = 4;
  localparam int IDX_DLL  = 8;
  localparam int IDX_MODE = 9;
  localparam int IDX_TEST = 10;
  localparam int LINK_SRST_BIT = 7;
  localparam int TEST_RST_BIT  = 2;
  localparam int MODE_BIT      = 0;
  localparam int FRAME_BITS    = 2 * DW;
  localparam int CNT_W         = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
    end else begin
      st[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import srp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sclk_s_i,
  input  logic          sdi_s_i,
  input  logic [DW-1:0] tx_byte_i,
  input  logic          tx_en_i,
  output logic          start_o,
  output logic          fall_o,
  output logic          cmt_o,
  output logic          cmt_wr_o,
  output logic [AW-1:0] cmt_addr_o,
  output logic [DW-1:0] cmt_data_o,
  output logic          sdo_o,
  output logic          sdo_en_o
);
  localparam int RX_W = AW + DW;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  localparam logic [3:0]       TXN  = 4'(DW);

  logic            cs_d, sclk_d;
  logic            rise;
  logic [CNT_W-1:0] cnt;
  logic [3:0]      fcnt;
  logic [RX_W-1:0] rx, rx_nxt;
  logic            wr_q;
  logic [DW-1:0]   tx_sh;
  logic            tx_on;

  assign start_o = cs_d & ~cs_s_i;
  assign rise    = ~cs_s_i & sclk_s_i & ~sclk_d;
  assign fall_o  = ~cs_s_i & ~sclk_s_i & sclk_d;
  assign rx_nxt  = {rx[RX_W-2:0], sdi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s_i;
      sclk_d <= sclk_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      fcnt  <= '0;
      rx    <= '0;
      wr_q  <= 1'b0;
      tx_sh <= '0;
      tx_on <= 1'b0;
    end else if (start_o) begin
      cnt   <= '0;
      fcnt  <= '0;
      rx    <= '0;
      wr_q  <= 1'b0;
      tx_sh <= tx_byte_i;
      tx_on <= tx_en_i;
    end else if (cs_s_i) begin
      tx_on <= 1'b0;
    end else begin
      if (rise && cnt < FULL) begin
        cnt <= cnt + 1'b1;
        rx  <= rx_nxt;
        if (cnt == '0) wr_q <= sdi_s_i;
      end
      if (fall_o && fcnt < TXN) begin
        fcnt  <= fcnt + 1'b1;
        tx_sh <= {tx_sh[DW-2:0], 1'b0};
        if (fcnt == TXN - 1'b1) tx_on <= 1'b0;
      end
    end
  end

  // commit registered on the final rising edge of a complete frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmt_o      <= 1'b0;
      cmt_wr_o   <= 1'b0;
      cmt_addr_o <= '0;
      cmt_data_o <= '0;
    end else begin
      cmt_o <= rise && (cnt == LAST);
      if (rise && (cnt == LAST)) begin
        cmt_wr_o   <= wr_q;
        cmt_addr_o <= rx_nxt[RX_W-1:DW];
        cmt_data_o <= rx_nxt[DW-1:0];
      end
    end
  end

  assign sdo_o    = tx_on & tx_sh[DW-1];
  assign sdo_en_o = tx_on;
endmodule

// File: rtl/srp_bank.sv
module srp_bank
  import srp_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [AW-1:0]  raddr_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           lock_i,
  output logic [NREG*DW-1:0] view_o,
  output logic           dll_pulse_o
);
  logic [DW-1:0] view [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (REG_TAB[i].kind == K_RO_STAT) begin : g_stat
      assign view[i] = {{(DW-1){1'b0}}, lock_i};
    end else if (REG_TAB[i].kind == K_RO_CONST) begin : g_const
      assign view[i] = REG_TAB[i].base;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= REG_TAB[i].base;
        else if (we_i && waddr_i == REG_TAB[i].addr)
          q <= (q & ~REG_TAB[i].wmask) | (wdata_i & REG_TAB[i].wmask);
      end
      assign view[i] = q;
    end
    assign view_o[i*DW +: DW] = view[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr_i == REG_TAB[i].addr) rdata_o = view[i];
  end

  // self-clearing bit: never stored, only pulsed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dll_pulse_o <= 1'b0;
    else dll_pulse_o <= we_i && (waddr_i == REG_TAB[IDX_DLL].addr) && wdata_i[0];
  end
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               sdo_en_o,
  input  logic               lock_err_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic               dll_rst_o,
  output logic               ser_rst_o,
  output logic               test_rst_o
);
  logic [3:0]    sync_q;
  logic          cs_sync, sclk_sync, sdi_sync, lock_sync;
  logic          start_p, fall_p;
  logic          bank_we, cmt_p, cmt_wr;
  logic [AW-1:0] cmt_addr;
  logic [DW-1:0] cmt_data;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] last_addr;
  logic          last_wr, have_prev;
  logic          mode_expl, tx_en;

  srp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lock_err_i, sdi_i, sclk_i, cs_ni}),
    .q_o   (sync_q)
  );
  assign {lock_sync, sdi_sync, sclk_sync, cs_sync} = sync_q;

  assign mode_expl = regs_o[IDX_MODE*DW + MODE_BIT];
  assign tx_en     = !mode_expl || (have_prev && !last_wr);

  srp_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (cs_sync),
    .sclk_s_i  (sclk_sync),
    .sdi_s_i   (sdi_sync),
    .tx_byte_i (rd_data),
    .tx_en_i   (tx_en),
    .start_o   (start_p),
    .fall_o    (fall_p),
    .cmt_o     (cmt_p),
    .cmt_wr_o  (cmt_wr),
    .cmt_addr_o(cmt_addr),
    .cmt_data_o(cmt_data),
    .sdo_o     (sdo_o),
    .sdo_en_o  (sdo_en_o)
  );

  assign bank_we = cmt_p & cmt_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr <= '0;
      last_wr   <= 1'b0;
      have_prev <= 1'b0;
    end else if (cmt_p) begin
      last_addr <= cmt_addr;
      last_wr   <= cmt_wr;
      have_prev <= 1'b1;
    end
  end

  srp_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bank_we),
    .waddr_i    (cmt_addr),
    .wdata_i    (cmt_data),
    .raddr_i    (last_addr),
    .rdata_o    (rd_data),
    .lock_i     (lock_sync),
    .view_o     (regs_o),
    .dll_pulse_o(dll_rst_o)
  );

  assign ser_rst_o  = regs_o[IDX_LINK*DW + LINK_SRST_BIT];
  assign test_rst_o = regs_o[IDX_TEST*DW + TEST_RST_BIT];
endmodule

// File: rtl/srp_chk.sv
module srp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_sync,
  input logic       start_p,
  input logic       fall_p,
  input logic       sdo_o,
  input logic       sdo_en_o,
  input logic       bank_we,
  input logic       dll_rst_o,
  input logic       mode_expl,
  input logic       last_wr,
  input logic [7:0] link_q,
  input logic [7:0] mode_q
);
  // R6
  sdo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_sync |=> !sdo_en_o);

  // R6
  sdo_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_p && !start_p && !cs_sync) |=> $stable(sdo_o));

  // R5
  expl_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_p && mode_expl && last_wr) |=> !sdo_en_o);

  // R9
  dll_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_rst_o |=> !dll_rst_o);

  // R9
  dll_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dll_rst_o) |-> $past(bank_we));

  // R10
  link_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_we |=> $stable(link_q));

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_we |=> $stable(mode_q));
endmodule

bind ser_reg_port srp_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_sync  (cs_sync),
  .start_p  (start_p),
  .fall_p   (fall_p),
  .sdo_o    (sdo_o),
  .sdo_en_o (sdo_en_o),
  .bank_we  (bank_we),
  .dll_rst_o(dll_rst_o),
  .mode_expl(mode_expl),
  .last_wr  (last_wr),
  .link_q   (regs_o[srp_pkg::IDX_LINK*8 +: 8]),
  .mode_q   (regs_o[srp_pkg::IDX_MODE*8 +: 8])
);

// File: tb/tb_ser_reg_port.sv
`timescale 1ns/1ps
module tb_ser_reg_port;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, lock = 1'b0;
  logic sdo_o, sdo_en_o, dll_rst_o, ser_rst_o, test_rst_o;
  logic [95:0] regs_o;
  int total = 0, bad = 0, dll_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ser_reg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .lock_err_i(lock), .regs_o(regs_o),
    .dll_rst_o(dll_rst_o), .ser_rst_o(ser_rst_o), .test_rst_o(test_rst_o)
  );

  always @(posedge clk) if (dll_rst_o) dll_cnt++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [5:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output logic oe0, output logic oe_late);
    logic [15:0] w;
    w = {wr, 1'b0, a, d};
    rd = '0; oe0 = 1'b0; oe_late = 1'b0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 16; i++) begin
      sdi = w[15-i];
      wait_clk(HALF);
      if (i < 8) begin
        rd = {rd[6:0], sdo_o};
        if (i == 0) oe0 = sdo_en_o;
      end else if (sdo_en_o) oe_late = 1'b1;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF + 2);
  endtask

  task automatic abort_xfer(input logic [5:0] a, input logic [7:0] d, input int nbits);
    logic [15:0] w;
    w = {1'b1, 1'b0, a, d};
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15-i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF + 2);
  endtask

  logic [7:0] rd;
  logic oe0, oel;

  task automatic t_reset();
    chk("R6 oe idle after reset", {7'b0, sdo_en_o}, 8'h00);
    chk("R10 ser_rst reset", {7'b0, ser_rst_o}, 8'h00);
    xfer(1'b0, 6'h01, 8'h00, rd, oe0, oel);
    chk("R1 R3 first frame returns 0x00", rd, 8'h04);
    chk("R3 oe auto", {7'b0, oe0}, 8'h01);
    chk("R6 oe low in data half", {7'b0, oel}, 8'h00);
    chk("R6 oe low after cs high", {7'b0, sdo_en_o}, 8'h00);
    xfer(1'b0, 6'h3E, 8'h00, rd, oe0, oel);
    chk("R1 reg 0x01", rd, 8'h00);
    xfer(1'b0, 6'h02, 8'h00, rd, oe0, oel);
    chk("R11 id 0x3E", rd, 8'h48);
    xfer(1'b0, 6'h04, 8'h00, rd, oe0, oel);
    chk("R1 reg 0x02", rd, 8'h24);
    xfer(1'b0, 6'h28, 8'h00, rd, oe0, oel);
    chk("R1 reg 0x04", rd, 8'h74);
    xfer(1'b0, 6'h00, 8'h00, rd, oe0, oel);
    chk("R1 reg 0x28", rd, 8'h0E);
  endtask

  task automatic t_write();
    xfer(1'b1, 6'h15, 8'hA5, rd, oe0, oel);
    xfer(1'b0, 6'h15, 8'h00, rd, oe0, oel);
    chk("R2 R3 write then readback", rd, 8'hA5);
    xfer(1'b1, 6'h00, 8'hFF, rd, oe0, oel);
    chk("R3 data after read frame", rd, 8'hA5);
    xfer(1'b0, 6'h00, 8'h00, rd, oe0, oel);
    chk("R11 mask on 0x00", rd, 8'h6D);
    xfer(1'b1, 6'h02, 8'hFF, rd, oe0, oel);
    xfer(1'b0, 6'h02, 8'h00, rd, oe0, oel);
    chk("R11 mask on 0x02", rd, 8'h3F);
  endtask

  task automatic t_unused();
    xfer(1'b1, 6'h30, 8'hFF, rd, oe0, oel);
    xfer(1'b1, 6'h3E, 8'h00, rd, oe0, oel);
    chk("R11 unused reads 0", rd, 8'h00);
    xfer(1'b0, 6'h00, 8'h00, rd, oe0, oel);
    chk("R11 id ignores write", rd, 8'h48);
  endtask

  task automatic t_status();
    lock = 1'b1;
    wait_clk(4);
    xfer(1'b1, 6'h07, 8'hFE, rd, oe0, oel);
    xfer(1'b0, 6'h07, 8'h00, rd, oe0, oel);
    chk("R8 status follows lock, write ignored", rd, 8'h01);
    lock = 1'b0;
    wait_clk(4);
    xfer(1'b0, 6'h00, 8'h00, rd, oe0, oel);
    chk("R8 status clear", rd, 8'h00);
  endtask

  task automatic t_dll();
    int c0;
    c0 = dll_cnt;
    xfer(1'b1, 6'h28, 8'hF1, rd, oe0, oel);
    chk("R9 single pulse", 8'(dll_cnt - c0), 8'h01);
    xfer(1'b0, 6'h28, 8'h00, rd, oe0, oel);
    xfer(1'b0, 6'h00, 8'h00, rd, oe0, oel);
    chk("R9 bit0 reads 0", rd, 8'hF0);
    chk("R9 no pulse on read", 8'(dll_cnt - c0), 8'h01);
  endtask

  task automatic t_sticky();
    xfer(1'b1, 6'h05, 8'h8E, rd, oe0, oel);
    xfer(1'b1, 6'h3D, 8'h04, rd, oe0, oel);
    xfer(1'b0, 6'h01, 8'h00, rd, oe0, oel);
    xfer(1'b1, 6'h01, 8'h00, rd, oe0, oel);
    chk("R10 ser_rst held", {7'b0, ser_rst_o}, 8'h01);
    chk("R10 test_rst held", {7'b0, test_rst_o}, 8'h01);
    xfer(1'b1, 6'h05, 8'h0E, rd, oe0, oel);
    xfer(1'b1, 6'h3D, 8'h00, rd, oe0, oel);
    chk("R10 ser_rst cleared", {7'b0, ser_rst_o}, 8'h00);
    chk("R10 test_rst cleared", {7'b0, test_rst_o}, 8'h00);
  endtask

  task automatic t_abort();
    xfer(1'b0, 6'h1C, 8'h00, rd, oe0, oel);
    abort_xfer(6'h1C, 8'h00, 12);
    chk("R7 oe low after abort", {7'b0, sdo_en_o}, 8'h00);
    abort_xfer(6'h3C, 8'h01, 15);
    xfer(1'b0, 6'h01, 8'h00, rd, oe0, oel);
    chk("R7 pointer and value kept", rd, 8'h61);
    chk("R7 mode still auto", {7'b0, oe0}, 8'h01);
  endtask

  task automatic t_explicit();
    xfer(1'b1, 6'h3C, 8'h01, rd, oe0, oel);
    xfer(1'b0, 6'h15, 8'h00, rd, oe0, oel);
    chk("R5 released after write", {7'b0, oe0}, 8'h00);
    xfer(1'b1, 6'h02, 8'h10, rd, oe0, oel);
    chk("R4 second frame drives", {7'b0, oe0}, 8'h01);
    chk("R4 data of read addr", rd, 8'hA5);
    xfer(1'b0, 6'h02, 8'h00, rd, oe0, oel);
    chk("R5 released after write 2", {7'b0, oe0}, 8'h00);
    xfer(1'b0, 6'h04, 8'h00, rd, oe0, oel);
    chk("R4 dummy read data", rd, 8'h10);
    xfer(1'b1, 6'h3C, 8'h00, rd, oe0, oel);
    chk("R4 write frame carries data", rd, 8'h74);
    xfer(1'b0, 6'h00, 8'h00, rd, oe0, oel);
    chk("R3 auto restored after write", {7'b0, oe0}, 8'h01);
    chk("R3 auto data", rd, 8'h00);
  endtask

  task automatic t_expl_reset();
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    xfer(1'b1, 6'h3C, 8'h01, rd, oe0, oel);
    chk("R1 baseline after second reset", rd, 8'h04);
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    xfer(1'b0, 6'h1C, 8'h00, rd, oe0, oel);
    chk("R1 mode reset to auto", {7'b0, oe0}, 8'h01);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_write();
    t_unused();
    t_status();
    t_dll();
    t_sticky();
    t_abort();
    t_explicit();
    t_expl_reset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule